// File: doc/BRIEF.md
# Masked Bit-Test Instruction Executor

This block runs one family of 8-bit controller instructions: each checks whether every bit picked out by a mask byte is set in a destination byte. It computes the inverted destination ANDed with the mask and updates the zero, sign and overflow flags from that result. The destination byte is never rewritten. Instruction bytes arrive one at a time over a valid/ready handshake. A `done` pulse marks the end of each instruction.

Operands live in an internal 256-byte register file. The host can preload it and read it back through a side port. A sixteen-register working window sits inside that file, at a page chosen by a register-pointer input. Six opcode layouts are decoded. Between them they cover working-register shorthand, full register addresses, immediate masks, and one level of indirection on either the source or the destination. The host can also load the flag register directly.

Top module: `mbt_exec`

## Requirements
- R1: After reset, `flags` is 0x00, `done` and `illegal` are low, `in_ready` is high, and every register-file byte reads 0x00 on `host_rdata`.
- R2: For each legal instruction, flag bit 6 (Z) is set when (~destination & mask) is zero, meaning all masked destination bits are 1. Otherwise Z is cleared.
- R3: For each legal instruction, flag bit 5 (S) takes bit 7 of (~destination & mask), and flag bit 4 (V) is cleared.
- R4: A legal instruction leaves flag bits 7, 3, 2, 1 and 0 unchanged. This includes values loaded earlier through `host_flag_we`.
- R5: Opcode 0x62 takes two bytes. In the second byte, the upper nibble names the destination working register and the lower nibble names the mask working register.
- R6: Opcode 0x63 takes two bytes with the same nibble layout as 0x62. The mask is read from the register-file address held in the named source working register.
- R7: Opcode 0x64 takes three bytes: opcode, then mask register address, then destination register address.
- R8: Opcode 0x65 takes three bytes: opcode, then source pointer address, then destination address. The mask is the byte at the address held in the pointer register.
- R9: Opcode 0x66 takes three bytes: opcode, then destination address, then the immediate mask.
- R10: Opcode 0x67 takes three bytes: opcode, then destination pointer address, then the immediate mask. The destination is the byte at the address held in the pointer register.
- R11: An operand address whose upper nibble is 0xE selects working register n (its lower nibble). Working register n lives at register-file address {rp[7:4], n}.
- R12: No instruction changes any register-file byte.
- R13: Any other opcode byte is consumed alone. It leaves `flags` unchanged and raises `illegal` in the same cycle as `done`. The byte that follows is decoded as a new opcode.
- R14: `in_ready` is low while operands are resolved and the result is computed. `done` is a one-cycle pulse per instruction, and the flags are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte |
| rp | input | 8 | Register pointer; upper nibble selects the working-register page |
| host_we | input | 1 | Register-file write strobe |
| host_addr | input | 8 | Register-file address for host write and read |
| host_wdata | input | 8 | Register-file write data |
| host_rdata | output | 8 | Register-file read data at `host_addr` |
| host_flag_we | input | 1 | Flag-register load strobe |
| host_flag_wdata | input | 8 | Flag-register load value |
| flags | output | 8 | Flag register (C=7, Z=6, S=5, V=4, D=3, H=2) |
| done | output | 1 | Instruction finished |
| illegal | output | 1 | Finished instruction was an unknown opcode |

## Verification
Each of the six opcode layouts is driven with operands whose results differ.
- Masks that are fully covered by the destination set Z.
- A mask bit that is missing from the destination clears Z.
- A missing bit 7 sets S.

Together these cases show whether the byte order and nibble roles are right. They also show whether indirection is applied to the correct operand.

Further runs cover three more concerns:
- Flags preset to 0xFF show whether the C, D and H bits survive.
- A page change on `rp` shows whether working-register mapping is correct.
- An unknown opcode placed just before a valid instruction shows whether only a single byte is consumed.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
   typedef enum logic [2:0] {ST_OP, ST_B1, ST_B2, ST_IND, ST_EXEC} mbt_state_e;

   localparam logic [7:0] OP_WW  = 8'h62;
   localparam logic [7:0] OP_WIW = 8'h63;
   localparam logic [7:0] OP_RR  = 8'h64;
   localparam logic [7:0] OP_RIR = 8'h65;
   localparam logic [7:0] OP_RIM = 8'h66;
   localparam logic [7:0] OP_IIM = 8'h67;

   function automatic logic op_legal(input logic [7:0] op);
      return (op >= OP_WW) && (op <= OP_IIM);
   endfunction

   function automatic logic op_short(input logic [7:0] op);
      return (op == OP_WW) || (op == OP_WIW);
   endfunction

   function automatic logic op_indirect(input logic [7:0] op);
      return (op == OP_WIW) || (op == OP_RIR) || (op == OP_IIM);
   endfunction
endpackage

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] ra_h,
   output logic [DATA_W-1:0] rd_h,
   input  logic [ADDR_W-1:0] ra_a,
   output logic [DATA_W-1:0] rd_a,
   input  logic [ADDR_W-1:0] ra_b,
   output logic [DATA_W-1:0] rd_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rd_h = mem[ra_h];
   assign rd_a = mem[ra_a];
   assign rd_b = mem[ra_b];
endmodule

// File: rtl/mbt_alu.sv
module mbt_alu #(
   parameter int DATA_W = 8,
   parameter int Z_BIT  = 6,
   parameter int S_BIT  = 5,
   parameter int V_BIT  = 4
) (
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] flags_in,
   output logic [DATA_W-1:0] flags_out
);
   logic [DATA_W-1:0] res;

   always_comb begin
      res              = ~dst & mask;
      flags_out        = flags_in;
      flags_out[Z_BIT] = (res == '0);
      flags_out[S_BIT] = res[DATA_W-1];
      flags_out[V_BIT] = 1'b0;
   end
endmodule

// File: rtl/mbt_seq.sv
module mbt_seq
   import mbt_pkg::*;
#(
   parameter int         DATA_W  = 8,
   parameter logic [3:0] WIN_TAG = 4'hE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic [DATA_W-1:0] rp,
   output logic [DATA_W-1:0] ra_a,
   input  logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] ra_b,
   input  logic [DATA_W-1:0] rd_b,
   output logic              exec_fire,
   output logic              illegal_fire,
   output logic [DATA_W-1:0] dst_val,
   output logic [DATA_W-1:0] mask_val
);
   mbt_state_e        st;
   logic [DATA_W-1:0] op_q, b1_q, b2_q, ind_q;
   logic [DATA_W-1:0] dst_addr, src_addr;
   logic              src_ind, dst_ind, src_imm;

   function automatic logic [DATA_W-1:0] wreg(input logic [3:0] n);
      return {rp[DATA_W-1:DATA_W-4], n};
   endfunction

   function automatic logic [DATA_W-1:0] wmap(input logic [DATA_W-1:0] a);
      return (a[DATA_W-1:DATA_W-4] == WIN_TAG) ? wreg(a[3:0]) : a;
   endfunction

   always_comb begin
      dst_addr = wmap(b1_q);
      src_addr = wmap(b2_q);
      src_ind  = 1'b0;
      dst_ind  = 1'b0;
      src_imm  = 1'b0;
      case (op_q)
         OP_WW, OP_WIW: begin
            dst_addr = wreg(b1_q[7:4]);
            src_addr = wreg(b1_q[3:0]);
            src_ind  = (op_q == OP_WIW);
         end
         OP_RR, OP_RIR: begin
            src_addr = wmap(b1_q);
            dst_addr = wmap(b2_q);
            src_ind  = (op_q == OP_RIR);
         end
         OP_RIM:  src_imm = 1'b1;
         default: begin
            src_imm = 1'b1;
            dst_ind = 1'b1;
         end
      endcase
   end

   always_comb begin
      if (st == ST_IND) begin
         ra_a = src_ind ? src_addr : dst_addr;
      end else begin
         ra_a = dst_ind ? ind_q : dst_addr;
      end
      ra_b         = src_ind ? ind_q : src_addr;
      dst_val      = rd_a;
      mask_val     = src_imm ? b2_q : rd_b;
      in_ready     = (st == ST_OP) || (st == ST_B1) || (st == ST_B2);
      exec_fire    = (st == ST_EXEC);
      illegal_fire = (st == ST_OP) && in_valid && !op_legal(in_data);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_OP;
         op_q  <= '0;
         b1_q  <= '0;
         b2_q  <= '0;
         ind_q <= '0;
      end else begin
         case (st)
            ST_OP: if (in_valid && op_legal(in_data)) begin
               op_q <= in_data;
               st   <= ST_B1;
            end
            ST_B1: if (in_valid) begin
               b1_q <= in_data;
               if (op_short(op_q)) st <= op_indirect(op_q) ? ST_IND : ST_EXEC;
               else                st <= ST_B2;
            end
            ST_B2: if (in_valid) begin
               b2_q <= in_data;
               st   <= op_indirect(op_q) ? ST_IND : ST_EXEC;
            end
            ST_IND: begin
               ind_q <= rd_a;
               st    <= ST_EXEC;
            end
            default: st <= ST_OP;
         endcase
      end
   end
endmodule

// File: rtl/mbt_exec.sv
module mbt_exec #(
   parameter int         DATA_W         = 8,
   parameter logic [3:0] WIN_TAG        = 4'hE,
   parameter int         Z_BIT          = 6,
   parameter int         S_BIT          = 5,
   parameter int         V_BIT          = 4,
   parameter bit         CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic [DATA_W-1:0] rp,
   input  logic              host_we,
   input  logic [DATA_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              host_flag_we,
   input  logic [DATA_W-1:0] host_flag_wdata,
   output logic [DATA_W-1:0] flags,
   output logic              done,
   output logic              illegal
);
   localparam int ADDR_W = DATA_W;

   if (DATA_W != 8) begin : g_bad_width
      $error("mbt_exec: DATA_W must be 8");
   end
   if (Z_BIT == S_BIT || Z_BIT == V_BIT || S_BIT == V_BIT) begin : g_bad_bits
      $error("mbt_exec: flag bit positions must differ");
   end
   if (Z_BIT >= DATA_W || S_BIT >= DATA_W || V_BIT >= DATA_W) begin : g_bad_range
      $error("mbt_exec: flag bit position out of range");
   end

   logic [ADDR_W-1:0] ra_a, ra_b;
   logic [DATA_W-1:0] rd_a, rd_b, dst_val, mask_val, flags_nxt;
   logic              exec_fire, illegal_fire;
   logic [DATA_W-1:0] flags_q;
   logic              done_q, ill_q;

   mbt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(host_we), .waddr(host_addr), .wdata(host_wdata),
      .ra_h(host_addr), .rd_h(host_rdata),
      .ra_a(ra_a), .rd_a(rd_a),
      .ra_b(ra_b), .rd_b(rd_b)
   );

   mbt_seq #(.DATA_W(DATA_W), .WIN_TAG(WIN_TAG)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .rp(rp),
      .ra_a(ra_a), .rd_a(rd_a), .ra_b(ra_b), .rd_b(rd_b),
      .exec_fire(exec_fire), .illegal_fire(illegal_fire),
      .dst_val(dst_val), .mask_val(mask_val)
   );

   mbt_alu #(.DATA_W(DATA_W), .Z_BIT(Z_BIT), .S_BIT(S_BIT), .V_BIT(V_BIT)) u_alu (
      .dst(dst_val), .mask(mask_val), .flags_in(flags_q), .flags_out(flags_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         done_q  <= 1'b0;
         ill_q   <= 1'b0;
      end else begin
         done_q <= exec_fire || illegal_fire;
         ill_q  <= illegal_fire;
         if (exec_fire)         flags_q <= flags_nxt;
         else if (host_flag_we) flags_q <= host_flag_wdata;
      end
   end

   assign flags   = flags_q;
   assign done    = done_q;
   assign illegal = ill_q;
endmodule

// File: rtl/mbt_exec_chk.sv
module mbt_exec_chk #(
   parameter int DATA_W = 8,
   parameter int Z_BIT  = 6,
   parameter int S_BIT  = 5,
   parameter int V_BIT  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              illegal,
   input logic              in_ready,
   input logic              host_flag_we,
   input logic [DATA_W-1:0] flags
);
   localparam logic [DATA_W-1:0] KEEP =
      ~((DATA_W'(1) << Z_BIT) | (DATA_W'(1) << S_BIT) | (DATA_W'(1) << V_BIT));

   a_r3_v_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal) |-> !flags[V_BIT]);

   a_r13_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);

   a_r13_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !$past(host_flag_we)) |-> (flags == $past(flags)));

   a_r4_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal && !$past(host_flag_we)) |-> ((flags & KEEP) == ($past(flags) & KEEP)));

   a_r14_busy_after_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal) |-> $past(!in_ready));
endmodule

bind mbt_exec mbt_exec_chk #(.DATA_W(DATA_W), .Z_BIT(Z_BIT), .S_BIT(S_BIT), .V_BIT(V_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .illegal(illegal),
   .in_ready(in_ready), .host_flag_we(host_flag_we), .flags(flags)
);

// File: tb/mbt_exec_tb_top.sv
module mbt_exec_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready;
   logic [7:0] rp = 8'h20;
   logic       host_we = 1'b0;
   logic [7:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_flag_we = 1'b0;
   logic [7:0] host_flag_wdata = '0;
   logic [7:0] flags;
   logic       done, illegal;

   int checks = 0;
   int failures = 0;

   typedef struct {
      logic [7:0] fl;
      logic       ill;
      string      tag;
   } exp_t;
   exp_t sb[$];
   logic [7:0] mflags = '0;

   always #2 clk = ~clk;

   mbt_exec dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .rp(rp), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_flag_we(host_flag_we), .host_flag_wdata(host_flag_wdata),
      .flags(flags), .done(done), .illegal(illegal)
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] tcm(input logic [7:0] cur, input logic [7:0] d, input logic [7:0] m);
      logic [7:0] r, f;
      r = ~d & m;
      f = cur;
      f[6] = (r == 8'h00);
      f[5] = r[7];
      f[4] = 1'b0;
      return f;
   endfunction

   // monitor: pops the expected result on every done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check8("R14 unexpected done", 8'h01, 8'h00);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check8({e.tag, " flags"}, flags, e.fl);
            check8({e.tag, " illegal"}, {7'd0, illegal}, {7'd0, e.ill});
         end
      end
   end

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      host_addr = a;
      #1 check8(tag, host_rdata, exp);
   endtask

   task automatic wait_idle();
      while (sb.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic issue(input int n, input logic [7:0] op, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] d, input logic [7:0] m,
                        input string tag);
      exp_t e;
      mflags = tcm(mflags, d, m);
      e.fl = mflags; e.ill = 1'b0; e.tag = tag;
      sb.push_back(e);
      send(op);
      send(b1);
      if (n == 3) send(b2);
      check8({tag, " R14 busy"}, {7'd0, in_ready}, 8'h00);
   endtask

   task automatic issue_bad(input logic [7:0] op);
      exp_t e;
      e.fl = mflags; e.ill = 1'b1; e.tag = "R13";
      sb.push_back(e);
      send(op);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1 flags", flags, 8'h00);
      check8("R1 done", {7'd0, done}, 8'h00);
      check8("R1 illegal", {7'd0, illegal}, 8'h00);
      check8("R1 in_ready", {7'd0, in_ready}, 8'h01);
      host_rd("R1 rf", 8'h5D, 8'h00);

      // working page 0x20 (rp = 0x20)
      host_wr(8'h23, 8'h45); host_wr(8'h27, 8'h01);
      issue(2, 8'h62, 8'h37, 8'h00, 8'h45, 8'h01, "R5 R2 ww");

      host_wr(8'h2E, 8'hF3); host_wr(8'h25, 8'hCB); host_wr(8'hCB, 8'h88);
      issue(2, 8'h63, 8'hE5, 8'h00, 8'hF3, 8'h88, "R6 R2 w-ind");

      host_wr(8'hD4, 8'h04); host_wr(8'h20, 8'h80);
      issue(3, 8'h64, 8'hE0, 8'hD4, 8'h04, 8'h80, "R7 R3 R11 rr");

      host_wr(8'hDF, 8'hFF); host_wr(8'h07, 8'h1F); host_wr(8'h1F, 8'hBD);
      issue(3, 8'h65, 8'h07, 8'hDF, 8'hFF, 8'hBD, "R8 r-ind");

      host_wr(8'h2D, 8'hF2);
      issue(3, 8'h66, 8'hED, 8'h02, 8'hF2, 8'h02, "R9 R11 imm");

      host_wr(8'h5D, 8'hA0); host_wr(8'hA0, 8'h0F);
      issue(3, 8'h67, 8'h5D, 8'h10, 8'h0F, 8'h10, "R10 ind-imm");

      // S set with Z clear on an immediate form
      host_wr(8'h40, 8'h7F);
      issue(3, 8'h66, 8'h40, 8'h81, 8'h7F, 8'h81, "R3 sign");
      wait_idle();

      // preserved bits
      @(negedge clk);
      host_flag_we = 1'b1; host_flag_wdata = 8'hFF;
      @(negedge clk);
      host_flag_we = 1'b0;
      mflags = 8'hFF;
      check8("R4 preload", flags, 8'hFF);
      issue(2, 8'h62, 8'h37, 8'h00, 8'h45, 8'h01, "R4 keep");
      wait_idle();
      check8("R4 value", flags, 8'hCF);

      // illegal opcode followed at once by a legal one
      issue_bad(8'h00);
      issue(2, 8'h62, 8'h37, 8'h00, 8'h45, 8'h01, "R13 next");
      issue_bad(8'h68);
      wait_idle();

      // different working page
      rp = 8'h50;
      host_wr(8'h53, 8'h0F); host_wr(8'h57, 8'h10);
      issue(2, 8'h62, 8'h37, 8'h00, 8'h0F, 8'h10, "R11 page");
      wait_idle();
      rp = 8'h20;

      // destinations untouched
      host_rd("R12 d4", 8'hD4, 8'h04);
      host_rd("R12 a0", 8'hA0, 8'h0F);
      host_rd("R12 r3", 8'h23, 8'h45);
      host_rd("R12 40", 8'h40, 8'h7F);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule